// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer Core

A 16-bit up-counting timer driven from the system clock through a selectable prescaler. A 4-bit waveform mode decides where the count wraps. It can run the full 16-bit range, clear on a match with compare register A or with the capture register, or run a single-slope sequence up to a fixed 8, 9 or 10-bit limit or to a register-defined limit. Three event flags (overflow, compare A, compare B) are each gated by an enable bit onto a single interrupt request line.

Software reaches every register through an 8-bit bus. Sixteen-bit registers are moved through one shared staging byte. A write of the upper byte parks it in the staging byte, and the write of the lower byte commits both halves at once. A read of the lower byte copies the upper half into the staging byte, so a later upper-byte read returns a half that matches. The live count, a pulse on the tick that leaves TOP and a pulse on the tick that leaves zero are exported for the output-compare and capture units.

Top module: `tmr_core`

## Requirements
- R1: Control register (address 0) holds clock select in bits [2:0] and mode in bits [6:3]. Clock select 000 stops the count; 001, 010, 011, 100 and 101 advance it once per 1, 8, 64, 256 and 1024 clock cycles; 110 and 111 also stop it. The prescaler restarts from zero whenever clock select is 000, so the first tick after a start comes exactly one full division later.
- R2: Mode 0, and every mode code not named in R3 to R5, counts 0 to 0xFFFF, wraps to 0 and sets the overflow flag on the tick that leaves 0xFFFF. A compare match does not clear the counter in these modes.
- R3: Mode 4 clears the counter on the tick that leaves the compare-A value, and mode 12 does the same with the capture register, giving a period of TOP+1 ticks. In these modes the overflow flag is set only when the count leaves 0xFFFF (after a preset above TOP).
- R4: Modes 5, 6 and 7 wrap at a fixed TOP of 0x00FF, 0x01FF and 0x03FF, and set the overflow flag on the tick that leaves TOP.
- R5: Mode 14 wraps at the capture register value and mode 15 at the compare-A value, setting the overflow flag on the tick that leaves TOP.
- R6: Compare flag A (or B) is set on a tick at which the count equals compare register A (or B).
- R7: The flag register (address 2) has overflow in bit 0, compare A in bit 1 and compare B in bit 2. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle wins over a clear.
- R8: The enable register (address 1) uses the same bit positions. The interrupt request is high exactly when some flag and its enable are both set. A one-cycle acknowledge with index 0, 1 or 2 clears that flag only.
- R9: Sixteen-bit registers sit at lower/upper address pairs 4/5 (count), 6/7 (compare A), 8/9 (compare B) and 10/11 (capture). An upper-byte write alone changes no register. A lower-byte write commits {staging, data}. A lower-byte read loads the staging byte with the upper half of the same value, and an upper-byte read returns the staging byte.
- R10: A lower-byte write of the count presets it. In that cycle the write takes priority over the tick, and no flag or pulse is raised.
- R11: at_top is high on a tick that leaves TOP, after which the count is zero. at_bot is high on a tick that leaves zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for staging-byte side effect) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| ack_idx | input | 3 | Flag index cleared by the acknowledge |
| irq | output | 1 | Interrupt request |
| count | output | 16 | Live counter value |
| at_top | output | 1 | Tick leaving TOP |
| at_bot | output | 1 | Tick leaving zero |

## Verification
The hardest situations to reach from the ports are the ones where two events share one edge. Examples are a counter preset landing on the very tick where the count equals a compare value, and a staged count read that straddles a carry out of the lower byte. The bench sets these up by presetting the counter one below the compare value while the prescaler runs at full rate, so that the committing low-byte write falls on the matching tick. It also starts a read on a count of 0x00FF, so that the carry into the upper byte happens between the two byte reads. The wrap modes are swept over several TOP values, with count and pulses compared against modular arithmetic on every cycle.

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int PSW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        irq_ack,
  input  logic [2:0]  ack_idx,
  output logic        irq,
  output logic [15:0] count,
  output logic        at_top,
  output logic        at_bot
);
  localparam logic [15:0] MAXV = 16'hFFFF;

  logic [2:0]     cs;
  logic [3:0]     mode;
  logic [2:0]     ien, flg;
  logic [15:0]    cnt, cmpa, cmpb, capr, top;
  logic [7:0]     tmp;
  logic [PSW-1:0] psc;
  logic           tick, pwm, cnt_wr, ovf_set, hit_a, hit_b;
  logic [2:0]     clr_sw, clr_ack;

  always_comb begin
    case (cs)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &psc[2:0];
      3'd3:    tick = &psc[5:0];
      3'd4:    tick = &psc[7:0];
      3'd5:    tick = &psc[9:0];
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    pwm = 1'b0;
    case (mode)
      4'd4:    top = cmpa;
      4'd12:   top = capr;
      4'd5:    begin top = 16'h00FF; pwm = 1'b1; end
      4'd6:    begin top = 16'h01FF; pwm = 1'b1; end
      4'd7:    begin top = 16'h03FF; pwm = 1'b1; end
      4'd14:   begin top = capr;     pwm = 1'b1; end
      4'd15:   begin top = cmpa;     pwm = 1'b1; end
      default: top = MAXV;
    endcase
  end

  assign cnt_wr  = bus_wr && bus_addr == 4'd4;
  assign at_top  = tick && !cnt_wr && cnt == top;
  assign at_bot  = tick && !cnt_wr && cnt == 16'h0;
  assign ovf_set = pwm ? at_top : (tick && !cnt_wr && cnt == MAXV);
  assign hit_a   = tick && !cnt_wr && cnt == cmpa;
  assign hit_b   = tick && !cnt_wr && cnt == cmpb;
  assign clr_sw  = (bus_wr && bus_addr == 4'd2) ? bus_wdata[2:0] : 3'b000;
  assign clr_ack = irq_ack ? (3'b001 << ack_idx) : 3'b000;
  assign irq     = |(flg & ien);
  assign count   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc <= '0;
    else if (cs == 3'd0) psc <= '0;
    else psc <= psc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_wr) cnt <= {tmp, bus_wdata};
    else if (tick) cnt <= (cnt == top) ? 16'h0 : cnt + 16'h1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else flg <= (flg & ~(clr_sw | clr_ack)) | {hit_b, hit_a, ovf_set};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs   <= '0;
      mode <= '0;
      ien  <= '0;
      cmpa <= '0;
      cmpb <= '0;
      capr <= '0;
      tmp  <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          4'd0:                      {mode, cs} <= bus_wdata[6:0];
          4'd1:                      ien  <= bus_wdata[2:0];
          4'd6:                      cmpa <= {tmp, bus_wdata};
          4'd8:                      cmpb <= {tmp, bus_wdata};
          4'd10:                     capr <= {tmp, bus_wdata};
          4'd5, 4'd7, 4'd9, 4'd11:   tmp  <= bus_wdata;
          default: ;
        endcase
      end else if (bus_rd) begin
        case (bus_addr)
          4'd4:    tmp <= cnt[15:8];
          4'd6:    tmp <= cmpa[15:8];
          4'd8:    tmp <= cmpb[15:8];
          4'd10:   tmp <= capr[15:8];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      4'd0:                    bus_rdata = {1'b0, mode, cs};
      4'd1:                    bus_rdata = {5'b0, ien};
      4'd2:                    bus_rdata = {5'b0, flg};
      4'd4:                    bus_rdata = cnt[7:0];
      4'd6:                    bus_rdata = cmpa[7:0];
      4'd8:                    bus_rdata = cmpb[7:0];
      4'd10:                   bus_rdata = capr[7:0];
      4'd5, 4'd7, 4'd9, 4'd11: bus_rdata = tmp;
      default:                 bus_rdata = 8'h00;
    endcase
  end
endmodule

module tmr_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        cnt_wr,
  input logic [2:0]  cs,
  input logic [3:0]  mode,
  input logic [2:0]  ien,
  input logic [2:0]  flg,
  input logic [15:0] cmpa,
  input logic [15:0] count,
  input logic        at_top,
  input logic        irq
);
  a_r1_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'd0 && !cnt_wr) |=> $stable(count));

  a_r11_top_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |=> count == 16'h0);

  a_r2_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0 && tick && !cnt_wr && count == 16'hFFFF) |=> flg[0]);

  a_r6_cmpa_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && count == cmpa) |=> flg[1]);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien != 3'b000);
endmodule

bind tmr_core tmr_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cs(cs), .mode(mode),
  .ien(ien), .flg(flg), .cmpa(cmpa), .count(count), .at_top(at_top), .irq(irq)
);

// File: tb/tmr_core_bench.sv
`timescale 1ns/1ps
module tmr_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_ack = 1'b0;
  logic [2:0]  ack_idx = '0;
  logic        irq, at_top, at_bot;
  logic [15:0] count;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_core u_tmr_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack), .ack_idx(ack_idx),
    .irq(irq), .count(count), .at_top(at_top), .at_bot(at_bot)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a + 4'd1, v[15:8]);
    wr(a, v[7:0]);
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(a, lo);
    rd8(a + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ctl(input logic [3:0] m, input logic [2:0] c);
    wr(4'd0, {1'b0, m, c});
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    int divs[5];
    int tops[5];
    int fm[5];
    int ft[5];
    divs = '{1, 8, 64, 256, 1024};
    tops = '{0, 1, 2, 5, 9};
    fm = '{5, 6, 7, 14, 15};
    ft = '{16'h00FF, 16'h01FF, 16'h03FF, 16'h0123, 16'h0456};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R11 reset count", count, 0);
    chk("R8 reset irq", irq, 0);
    rd8(4'd2, b); chk("R7 reset flags", b, 0);
    rd8(4'd0, b); chk("R1 reset ctrl", b, 0);
    rd16(4'd6, w); chk("R9 reset cmpa", w, 0);

    // R9 staged access
    wr16(4'd8, 16'h1234);
    rd16(4'd8, w); chk("R9 cmpb readback", w, 16'h1234);
    wr(4'd9, 8'hAB);
    rd16(4'd8, w); chk("R9 upper write alone", w, 16'h1234);
    wr16(4'd10, 16'hBEEF);
    rd16(4'd10, w); chk("R9 capr readback", w, 16'hBEEF);
    ctl(4'd9, 3'd3);
    rd8(4'd0, b); chk("R1 ctrl fields", b, 8'h4B);
    ctl(4'd0, 3'd0);

    wr16(4'd6, 16'h7000);
    wr16(4'd8, 16'h7100);

    // R9 atomic read across carry
    wr16(4'd4, 16'h00FF);
    ctl(4'd0, 3'd1);
    rd16(4'd4, w); chk("R9 atomic count read", w, 16'h00FF);
    ctl(4'd0, 3'd0);

    // R1 prescaler sweep
    for (int i = 0; i < 5; i++) begin
      wr16(4'd4, 16'h0000);
      ctl(4'd0, 3'(i + 1));
      tick_n(divs[i] * 3 - 1);
      chk($sformatf("R1 div %0d before", divs[i]), count, 2);
      tick_n(1);
      chk($sformatf("R1 div %0d at", divs[i]), count, 3);
      ctl(4'd0, 3'd0);
    end
    for (int c = 6; c < 8; c++) begin
      wr16(4'd4, 16'h0042);
      ctl(4'd0, 3'(c));
      tick_n(40);
      chk("R1 unused select stopped", count, 16'h0042);
      ctl(4'd0, 3'd0);
    end
    wr16(4'd4, 16'h0000);
    ctl(4'd0, 3'd2);
    tick_n(4);
    ctl(4'd0, 3'd0);
    ctl(4'd0, 3'd2);
    tick_n(7);
    chk("R1 prescaler restart before", count, 0);
    tick_n(1);
    chk("R1 prescaler restart at", count, 1);
    ctl(4'd0, 3'd0);
    tick_n(20);
    chk("R1 stopped holds", count, 1);

    // R2 normal wrap
    wr(4'd2, 8'hFF);
    wr16(4'd4, 16'hFFFD);
    ctl(4'd0, 3'd1);
    tick_n(3);
    chk("R2 wrap to zero", count, 0);
    rd8(4'd2, b); chk("R2 overflow flag", b, 1);
    chk("R8 no irq when disabled", irq, 0);
    ctl(4'd0, 3'd0);

    // R3 CTC sweeps
    for (int md = 0; md < 2; md++) begin
      for (int t = 0; t < 5; t++) begin
        int tp = tops[t];
        ctl(4'd0, 3'd0);
        wr(4'd2, 8'hFF);
        if (md == 0) begin wr16(4'd6, 16'(tp)); wr16(4'd10, 16'h7000); end
        else begin wr16(4'd10, 16'(tp)); wr16(4'd6, 16'h7000); end
        wr16(4'd4, 16'h0000);
        ctl(md == 0 ? 4'd4 : 4'd12, 3'd1);
        for (int k = 1; k <= 3 * (tp + 1); k++) begin
          int e = k % (tp + 1);
          @(negedge clk);
          chk("R3 ctc count", count, e);
          chk("R11 at_top", at_top, e == tp);
          chk("R11 at_bot", at_bot, e == 0);
        end
        ctl(md == 0 ? 4'd4 : 4'd12, 3'd0);
        rd8(4'd2, b);
        chk("R6 flags after ctc", b, md == 0 ? 2 : 0);
      end
    end
    ctl(4'd0, 3'd0);
    wr(4'd2, 8'hFF);
    wr16(4'd6, 16'd10);
    wr16(4'd4, 16'hFFFF);
    ctl(4'd4, 3'd1);
    tick_n(1);
    chk("R3 ctc passes max", count, 0);
    ctl(4'd4, 3'd0);
    rd8(4'd2, b); chk("R3 ovf above top", b, 1);

    // R4/R5 single slope
    for (int i = 0; i < 5; i++) begin
      ctl(4'd0, 3'd0);
      wr(4'd2, 8'hFF);
      wr16(4'd10, fm[i] == 14 ? 16'(ft[i]) : 16'h7200);
      wr16(4'd6, fm[i] == 15 ? 16'(ft[i]) : 16'h7000);
      wr16(4'd4, 16'(ft[i] - 1));
      ctl(4'(fm[i]), 3'd1);
      tick_n(1);
      chk(i < 3 ? "R4 reach top" : "R5 reach top", count, ft[i]);
      chk("R11 pulse at top", at_top, 1);
      tick_n(1);
      chk(i < 3 ? "R4 wrap" : "R5 wrap", count, 0);
      ctl(4'(fm[i]), 3'd0);
      rd8(4'd2, b);
      chk(i < 3 ? "R4 ovf at top" : "R5 ovf at top", b, fm[i] == 15 ? 3 : 1);
    end

    // R2 unlisted mode
    ctl(4'd0, 3'd0);
    wr(4'd2, 8'hFF);
    wr16(4'd6, 16'd3);
    wr16(4'd4, 16'd3);
    ctl(4'd9, 3'd1);
    tick_n(1);
    chk("R2 unlisted no clear", count, 4);
    wr16(4'd4, 16'hFFFF);
    tick_n(1);
    chk("R2 unlisted wrap", count, 0);
    ctl(4'd9, 3'd0);
    rd8(4'd2, b); chk("R2 unlisted flags", b, 3);

    // R10 preset wins over match
    ctl(4'd0, 3'd0);
    wr(4'd2, 8'hFF);
    wr16(4'd6, 16'h0020);
    wr16(4'd4, 16'h001F);
    ctl(4'd0, 3'd1);
    wr16(4'd4, 16'h0040);
    ctl(4'd0, 3'd0);
    chk("R10 preset count", count, 16'h0041);
    rd8(4'd2, b); chk("R10 no flag on preset", b, 0);

    // R7/R8 flags and irq
    wr(4'd1, 8'h02);
    wr16(4'd6, 16'd5);
    wr16(4'd4, 16'd5);
    ctl(4'd0, 3'd1);
    ctl(4'd0, 3'd0);
    #1 chk("R8 irq from cmpa", irq, 1);
    wr(4'd2, 8'h00);
    rd8(4'd2, b); chk("R7 zero write ignored", b, 2);
    wr(4'd2, 8'h01);
    rd8(4'd2, b); chk("R7 clear other bit", b, 2);
    wr(4'd2, 8'h02);
    rd8(4'd2, b); chk("R7 write one clears", b, 0);
    #1 chk("R8 irq drops", irq, 0);
    wr16(4'd4, 16'd5);
    ctl(4'd0, 3'd1);
    ctl(4'd0, 3'd0);
    irq_ack = 1'b1; ack_idx = 3'd0;
    @(negedge clk);
    irq_ack = 1'b0;
    #1 chk("R8 ack other index", irq, 1);
    @(negedge clk);
    irq_ack = 1'b1; ack_idx = 3'd1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1 chk("R8 ack clears", irq, 0);
    wr16(4'd4, 16'd5);
    ctl(4'd0, 3'd1);
    ctl(4'd0, 3'd0);
    wr(4'd1, 8'h01);
    #1 chk("R8 masked flag", irq, 0);
    rd8(4'd2, b); chk("R6 flag kept while masked", b, 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule